// File: doc/BRIEF.md
# MII Management Master with Register Interface

This block gives a host access to the management registers of an Ethernet PHY through two 32-bit registers on a plain register bus. One register holds the command: PHY address, register index, direction and a busy flag. The other holds the data word. A write access loads the 16-bit value into the data register first and then writes the command register. A read access writes the command register, waits until busy clears, then takes the PHY value from the low half of the data register.

Each command sends one clause-22 frame on an MDC/MDIO pin pair, most significant bit first: 32 preamble ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, a 2-bit turnaround, and 16 data bits. MDC is the system clock divided by `MDC_DIV`. MDIO changes on MDC falling edges and is sampled on MDC rising edges. The pad is split into an output, an output enable and an input. A low enable means the pin is released.

Top module: `mii_mgmt_master`

## Requirements
- R1: After reset the command register reads 0 (busy clear), the data register reads 0, MDC is low and the MDIO output enable is low.
- R2: A command-register write (`reg_sel_i`=0) while idle sets busy (bit 0) from the next cycle. Busy stays set for exactly 64×`MDC_DIV` clock cycles and then reads 0.
- R3: Every frame starts with 32 ones, then `01`, then opcode `10` when command bit 1 is 0 (read) or `01` when it is 1 (write). Next come the PHY address from command bits 15:11 and the register index from command bits 10:6, each MSB first.
- R4: A write frame drives turnaround `10` and then data-register bits 15:0, MSB first, with the output enable high for all 64 bits.
- R5: A read frame drops the output enable for bit positions 46 to 63 (turnaround and data). The 16 MDIO values sampled on MDC rising edges during positions 48 to 63 land in data-register bits 15:0 when busy clears, and bits 31:16 read 0.
- R6: MDC has a period of `MDC_DIV` clocks and is high for `MDC_DIV`/2 of them. It stays low while idle. The MDIO output never changes while MDC is high.
- R7: A command-register write while busy is ignored. The command fields read back unchanged, the frame in flight is not altered and the busy time is not extended.
- R8: The command register reads back the last accepted PHY address in bits 15:11, the register index in bits 10:6 and the direction in bit 1, with busy in bit 0 and all other bits 0.
- R9: The MDIO output enable is low whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 command, 1 data |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO pin value |

## Verification
The bench plays the PHY. It records all 64 bit positions of each frame on MDC rising edges and answers reads by driving MDIO on falling edges, so a design that samples on the wrong edge or off by one bit returns a shifted read value.

A command written in the middle of a read targets a different PHY and register. A design that accepts it would show changed readback fields, a corrupted header or a longer busy time. Distinct PHY addresses and data patterns, including all-ones and alternating bits, expose swapped or reversed fields. Checks on the enable pattern catch a read that keeps driving through turnaround, and the measured MDC period and high time catch an off-by-one in the divider.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PHY_LSB    = 11;
  localparam int REG_LSB    = 6;
  localparam int DIR_BIT    = 1;
  localparam int BUSY_BIT   = 0;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic              wr;
  } mii_cmd_t;

  function automatic logic [FRAME_BITS-1:0] mk_frame(mii_cmd_t c, logic [DATA_W-1:0] wd);
    mk_frame = {32'hFFFF_FFFF, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regad,
                (c.wr ? 2'b10 : 2'b11), (c.wr ? wd : 16'hFFFF)};
  endfunction
endpackage

// File: rtl/mii_clk_div.sv
module mii_clk_div #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0] LAST    = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_o = run_i && (cnt_q == HALF_M1);
  assign fall_o = run_i && (cnt_q == LAST);
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (rise_o) mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !$past(run_i) |-> !mdc_o); // R6
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
  import mii_mgmt_pkg::*;
#(
  parameter int DIV = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mii_cmd_t          cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int FRAME_CYC = FRAME_BITS * DIV;
  localparam int CYC_W     = $clog2(FRAME_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic                  busy_q, is_rd_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [DATA_W-1:0]     rd_q;
  logic                  last_fall;

  assign last_fall = busy_q && fall_i && (idx_q == LAST_IDX);
  assign busy_o    = busy_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(is_rd_q && (idx_q >= IDX_W'(TA_POS)));
  assign rd_done_o = last_fall && is_rd_q;
  assign rdata_o   = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        is_rd_q <= !cmd_i.wr;
        sh_q    <= mk_frame(cmd_i, wdata_i);
        idx_q   <= '0;
        rd_q    <= '0;
      end
    end else begin
      if (rise_i && is_rd_q && (idx_q >= IDX_W'(DATA_POS)))
        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // frame-length watch, independent of the bit counter
  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cyc_q <= '0;
    else if (busy_q)  cyc_q <= cyc_q + 1'b1;
    else              cyc_q <= '0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cyc_q < CYC_W'(FRAME_CYC)); // R2
  AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdio_oe_o); // R9
  AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && is_rd_q && rise_i && (idx_q >= IDX_W'(DATA_POS)) |-> !mdio_oe_o); // R5
endmodule

// File: rtl/mii_csr.sv
module mii_csr
  import mii_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              start_o,
  output mii_cmd_t          cmd_o,
  output logic [DATA_W-1:0] wdata_o
);
  mii_cmd_t    cmd_q, cmd_new;
  logic [31:0] data_q;

  assign cmd_new.phy   = reg_wdata_i[PHY_LSB +: ADDR_W];
  assign cmd_new.regad = reg_wdata_i[REG_LSB +: ADDR_W];
  assign cmd_new.wr    = reg_wdata_i[DIR_BIT];
  assign start_o       = reg_we_i && !reg_sel_i && !busy_i;
  assign cmd_o         = cmd_new;
  assign wdata_o       = data_q[DATA_W-1:0];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o = data_q;
    end else begin
      reg_rdata_o[PHY_LSB +: ADDR_W] = cmd_q.phy;
      reg_rdata_o[REG_LSB +: ADDR_W] = cmd_q.regad;
      reg_rdata_o[DIR_BIT]           = cmd_q.wr;
      reg_rdata_o[BUSY_BIT]          = busy_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (start_o) cmd_q <= cmd_new;
      if (rd_done_i)                  data_q <= {{(32-DATA_W){1'b0}}, rdata_i};
      else if (reg_we_i && reg_sel_i) data_q <= reg_wdata_i;
    end
  end

  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(cmd_q)); // R7
endmodule

// File: rtl/mii_mgmt_master.sv
module mii_mgmt_master
  import mii_mgmt_pkg::*;
#(
  parameter int MDC_DIV = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_sel_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy, start, rise, fall, rd_done;
  mii_cmd_t          cmd;
  logic [DATA_W-1:0] wdata, rdata;

  mii_csr u_csr (
    .clk_i, .rst_ni, .reg_sel_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .rd_done_i(rd_done), .rdata_i(rdata),
    .start_o(start), .cmd_o(cmd), .wdata_o(wdata)
  );

  mii_clk_div #(.DIV(MDC_DIV)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mii_frame_engine #(.DIV(MDC_DIV)) u_eng (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .wdata_i(wdata),
    .rise_i(rise), .fall_i(fall), .mdio_i, .busy_o(busy), .mdio_o,
    .mdio_oe_o, .rd_done_o(rd_done), .rdata_o(rdata)
  );

  AST_MDIO_STABLE_MDC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o && $past(mdc_o) |-> $stable(mdio_o)); // R6
endmodule

// File: tb/mii_mgmt_master_bench.sv
`timescale 1ns/1ps
module mii_mgmt_master_bench;
  localparam int DIV = 64;
  localparam int BUSY_CYC = 64 * DIV;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        mdc, mdio_out, mdio_oe, mdio_in = 1'b1;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mii_mgmt_master #(.MDC_DIV(DIV)) u_mii_mgmt_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic bus_wr(logic s, logic [31:0] d);
    @(negedge clk); sel = s; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0; sel = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(logic [4:0] p, logic [4:0] r, logic w);
    return {16'b0, p, r, 4'b0, w, 1'b0};
  endfunction

  // PHY side: record each bit on MDC rise, answer reads on MDC fall
  task automatic phy_run(logic is_rd, logic [15:0] rv, output logic [63:0] bits,
                         output logic [63:0] oes);
    for (int i = 0; i < 64; i++) begin
      @(posedge mdc);
      bits[63-i] = mdio_out;
      oes[63-i]  = mdio_oe;
      if (is_rd && i >= 47 && i < 63) begin
        @(negedge mdc);
        mdio_in = rv[62-i];
      end
    end
    @(negedge clk); mdio_in = 1'b1;
  endtask

  task automatic busy_count(output int n);
    n = 0;
    while (rd[0] === 1'b1 && n < BUSY_CYC + 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [45:0] hdr(logic [4:0] p, logic [4:0] r, logic w);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sel = 1'b0; #0.1;
    check("R1 cmd reg", 64'(rd), 64'h0);
    check("R1 mdc", 64'(mdc), 64'h0);
    check("R9 oe idle", 64'(mdio_oe), 64'h0);
    sel = 1'b1; #0.1;
    check("R1 data reg", 64'(rd), 64'h0);
    sel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_write(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    logic [63:0] bits, oes;
    int n;
    bus_wr(1'b1, {16'hDEAD, d});
    bus_wr(1'b0, cmd_word(p, r, 1'b1));
    check("R8 readback", 64'(rd), 64'(cmd_word(p, r, 1'b1) | 32'h1));
    fork
      phy_run(1'b0, 16'h0, bits, oes);
      busy_count(n);
    join
    check("R2 busy time", 64'(n), 64'(BUSY_CYC));
    check("R3 write header", 64'(bits[63:18]), 64'(hdr(p, r, 1'b1)));
    check("R4 write ta+data", 64'(bits[17:0]), 64'({2'b10, d}));
    check("R4 oe", oes, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R9 oe after", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_read(logic [4:0] p, logic [4:0] r, logic [15:0] v, logic poke);
    logic [63:0] bits, oes;
    int n;
    bus_wr(1'b0, cmd_word(p, r, 1'b0));
    fork
      phy_run(1'b1, v, bits, oes);
      busy_count(n);
      if (poke) begin
        repeat (300) @(negedge clk);
        we = 1'b1; wd = cmd_word(~p, ~r, 1'b1);
        @(negedge clk); we = 1'b0;
        check("R7 fields held", 64'(rd), 64'(cmd_word(p, r, 1'b0) | 32'h1));
      end
    join
    check(poke ? "R7 busy time" : "R2 busy time", 64'(n), 64'(BUSY_CYC));
    check(poke ? "R7 header" : "R3 read header", 64'(bits[63:18]), 64'(hdr(p, r, 1'b0)));
    check("R5 oe pattern", oes, {46'h3FFF_FFFF_FFFF, 18'h0});
    sel = 1'b1; #0.1;
    check("R5 read data", 64'(rd), 64'({16'h0, v}));
    sel = 1'b0; #0.1;
    check("R8 readback idle", 64'(rd), 64'(cmd_word(p, r, 1'b0)));
  endtask

  task automatic t_mdc();
    int per, hi;
    bus_wr(1'b0, cmd_word(5'd3, 5'd4, 1'b0));
    @(posedge mdc);
    per = 0; hi = 0;
    do begin
      @(negedge clk);
      per++;
      if (mdc) hi++;
    end while (!(mdc === 1'b1 && per > 1 && hi > DIV / 2));
    check("R6 mdc period", 64'(per - 1), 64'(DIV));
    check("R6 mdc high", 64'(hi - 1), 64'(DIV / 2));
    while (rd[0] === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R6 mdc idle low", 64'(mdc), 64'h0);
  endtask

  initial begin
    t_reset();
    t_write(5'd1, 5'd0, 16'h8000);
    t_write(5'd31, 5'd21, 16'hA5C3);
    t_read(5'd1, 5'd2, 16'h7C0F, 1'b0);
    t_read(5'd18, 5'd31, 16'hFFFF, 1'b0);
    t_read(5'd9, 5'd6, 16'h5AA5, 1'b1);
    t_mdc();
    finish_run();
  end
endmodule